// File: doc/BRIEF.md
# Sequential 8-bit Multiply/Divide Engine

This engine does unsigned multiplication and unsigned division on two byte-wide operands, called the accumulator operand (A) and the auxiliary operand (B). A one-cycle start pulse, together with an operation select, captures both operands. The engine then runs a fixed number of step cycles and reports the result on its A and B outputs. At the same time it pulses a completion strobe and updates the carry and overflow flags.

A multiply returns the full 16-bit product split over the two outputs. The low byte goes to A and the high byte to B. Overflow is raised whenever the high byte is nonzero. A divide returns the quotient in A and the remainder in B. A zero divisor gives a defined result: both outputs are zero and overflow is set. Both operations always leave carry cleared.

Inside, the engine handles two result bits per step cycle. It uses a shift-and-add chain for the product and a restoring shift-and-subtract chain for the quotient. The surrounding processor sees a constant latency that does not depend on the operand values.

Top module: `muldiv8_unit`

## Requirements
- R1: A start accepted at a clock edge while idle sets busy at that edge. The results and a single-cycle done pulse appear at the fourth edge after it, with busy cleared at that same edge. Done stays low during the intervening cycles.
- R2: Every completed operation leaves the carry output at 0.
- R3: For a multiply, A out equals the low 8 bits of the product of the captured operands.
- R4: For a multiply, B out equals the high 8 bits of the product. OV is 1 exactly when the product exceeds 255. Otherwise B out is 0 and OV is 0.
- R5: For a divide with a captured divisor of 0, A out and B out are both 0 and OV is 1.
- R6: For a divide with a nonzero divisor, A out is the unsigned quotient, B out is the remainder (always below the divisor), and OV is 0.
- R7: A start asserted while busy is ignored. The running operation completes with its original operands and operation, and no extra operation follows.
- R8: The operands and the operation select are captured on the accepted start. Changes on a_in, b_in or op_sel afterwards have no effect on the result.
- R9: A out, B out, C and OV change only at the edge that raises done. They hold their values in all other cycles, whatever the inputs do.
- R10: op_sel encoding: 0 selects multiply, 1 selects divide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, accepted only while idle |
| op_sel | input | 1 | 0 = multiply, 1 = divide |
| a_in | input | 8 | Accumulator operand (multiplicand / dividend) |
| b_in | input | 8 | Auxiliary operand (multiplier / divisor) |
| a_out | output | 8 | Product low byte or quotient |
| b_out | output | 8 | Product high byte or remainder |
| c_out | output | 1 | Carry flag, cleared by every operation |
| ov_out | output | 1 | Overflow flag |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle completion strobe |

## Verification
The assertions assume that reset is held for at least one clock edge before the first start. They also assume that start and op_sel are settled ahead of the sampling edge, because the engine has no synchronizer on them.

The stimulus drives every input on the falling clock edge and holds reset low once it is released. It does keep start asserted and changes the operands while the engine is busy, since R7 and R8 say those inputs must be tolerated. The result checks sweep every A value against a spread of B values, and every B value against a few A values, for both operations. Zero, one and 255 are included on both sides.

// File: rtl/muldiv8_pkg.sv
package muldiv8_pkg;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } md_op_e;

endpackage

// File: rtl/muldiv8_seq.sv
module muldiv8_seq #(
  parameter int STEPS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic accept,
  output logic step_en,
  output logic last_step,
  output logic done
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic [CW-1:0] cnt_q;

  assign accept    = start && !busy;
  assign step_en   = busy;
  assign last_step = busy && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end else if (busy) begin
        if (cnt_q == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R1: an accepted start makes the engine busy at the next edge
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R1: done only closes out a busy period and drops busy
  p_done_tail_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R1: done is a single-cycle pulse
  p_done_single_r1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/muldiv8_mul_step.sv
module muldiv8_mul_step #(
  parameter int W   = 8,
  parameter int BPC = 2
) (
  input  logic [2*W-1:0] acc,
  input  logic [2*W-1:0] mcand,
  input  logic [BPC-1:0] mbits,
  output logic [2*W-1:0] acc_nxt
);
  logic [2*W-1:0] part [BPC+1];

  assign part[0] = acc;

  for (genvar i = 0; i < BPC; i++) begin : g_add
    assign part[i+1] = part[i] + (mbits[i] ? (mcand << i) : '0);
  end

  assign acc_nxt = part[BPC];

endmodule

// File: rtl/muldiv8_div_step.sv
module muldiv8_div_step #(
  parameter int W   = 8,
  parameter int BPC = 2
) (
  input  logic [W-1:0]   rem,
  input  logic [BPC-1:0] dbits,
  input  logic [W-1:0]   divisor,
  output logic [W-1:0]   rem_nxt,
  output logic [BPC-1:0] qbits
);
  logic [W-1:0] r [BPC+1];

  assign r[0] = rem;

  for (genvar i = 0; i < BPC; i++) begin : g_sub
    logic [W:0] trial;
    logic [W:0] diff;
    logic       fits;
    assign trial = {r[i], dbits[BPC-1-i]};
    assign diff  = trial - {1'b0, divisor};
    assign fits  = (trial >= {1'b0, divisor});
    assign r[i+1] = fits ? diff[W-1:0] : trial[W-1:0];
    assign qbits[BPC-1-i] = fits;
  end

  assign rem_nxt = r[BPC];

endmodule

// File: rtl/muldiv8_unit.sv
module muldiv8_unit #(
  parameter int W     = 8,
  parameter int STEPS = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         op_sel,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         c_out,
  output logic         ov_out,
  output logic         busy,
  output logic         done
);
  import muldiv8_pkg::*;

  localparam int BPC = W / STEPS;
  localparam int PW  = 2 * W;

  logic accept, step_en, last_step;

  md_op_e          op_q;
  logic [PW-1:0]   mc_q, acc_q, acc_nxt;
  logic [W-1:0]    mp_q;
  logic [W-1:0]    dvd_q, quo_q, rem_q, dsr_q, rem_nxt;
  logic [BPC-1:0]  qbits;
  logic [W-1:0]    quo_fin;

  muldiv8_seq #(.STEPS(STEPS)) seq_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .accept(accept), .step_en(step_en), .last_step(last_step), .done(done)
  );

  muldiv8_mul_step #(.W(W), .BPC(BPC)) mul_i (
    .acc(acc_q), .mcand(mc_q), .mbits(mp_q[BPC-1:0]), .acc_nxt(acc_nxt)
  );

  muldiv8_div_step #(.W(W), .BPC(BPC)) div_i (
    .rem(rem_q), .dbits(dvd_q[W-1 -: BPC]), .divisor(dsr_q),
    .rem_nxt(rem_nxt), .qbits(qbits)
  );

  assign quo_fin = {quo_q[W-BPC-1:0], qbits};

  // operand capture and iteration state
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= OP_MUL;
      mc_q  <= '0;
      mp_q  <= '0;
      acc_q <= '0;
      dvd_q <= '0;
      quo_q <= '0;
      rem_q <= '0;
      dsr_q <= '0;
    end else if (accept) begin
      op_q  <= md_op_e'(op_sel);
      mc_q  <= {{W{1'b0}}, a_in};
      mp_q  <= b_in;
      acc_q <= '0;
      dvd_q <= a_in;
      quo_q <= '0;
      rem_q <= '0;
      dsr_q <= b_in;
    end else if (step_en) begin
      mc_q  <= mc_q << BPC;
      mp_q  <= mp_q >> BPC;
      acc_q <= acc_nxt;
      dvd_q <= dvd_q << BPC;
      rem_q <= rem_nxt;
      quo_q <= quo_fin;
    end
  end

  // result registers, written only on the final step
  always_ff @(posedge clk) begin
    if (rst) begin
      a_out  <= '0;
      b_out  <= '0;
      c_out  <= 1'b0;
      ov_out <= 1'b0;
    end else if (last_step) begin
      c_out <= 1'b0;
      if (op_q == OP_MUL) begin
        a_out  <= acc_nxt[W-1:0];
        b_out  <= acc_nxt[PW-1:W];
        ov_out <= |acc_nxt[PW-1:W];
      end else if (dsr_q == '0) begin
        a_out  <= '0;
        b_out  <= '0;
        ov_out <= 1'b1;
      end else begin
        a_out  <= quo_fin;
        b_out  <= rem_nxt;
        ov_out <= 1'b0;
      end
    end
  end

  // R4: multiply overflow tracks a nonzero high byte
  p_mul_ov_r4: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_MUL) |-> (ov_out == (b_out != '0)));

  // R5: zero divisor yields zeros with overflow
  p_div_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_DIV && dsr_q == '0) |-> (a_out == '0 && b_out == '0 && ov_out));

  // R6: nonzero divisor gives remainder below divisor, no overflow
  p_div_rem_r6: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_DIV && dsr_q != '0) |-> (!ov_out && b_out < dsr_q));

  // R7 / R8: captured operation and divisor are frozen while busy
  p_capture_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_step) |=> ($stable(op_q) && $stable(dsr_q)));

  // R9: outputs move only with done
  p_hold_outputs_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(a_out) && $stable(b_out) && $stable(ov_out) && $stable(c_out)));

endmodule

// File: tb/muldiv8_unit_tb_top.sv
`timescale 1ns/1ps
module muldiv8_unit_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst, start, op_sel;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         c_out, ov_out, busy, done;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  muldiv8_unit #(.W(W), .STEPS(4)) dut_i (
    .clk(clk), .rst(rst), .start(start), .op_sel(op_sel),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
    .c_out(c_out), .ov_out(ov_out), .busy(busy), .done(done)
  );

  // R10: op 0 = multiply, 1 = divide
  task automatic model(input bit op, input int a, input int b,
                       output int ea, output int eb, output bit eov);
    int p;
    if (!op) begin
      p = a * b;
      ea = p % 256; eb = p / 256; eov = (p > 255);
    end else if (b == 0) begin
      ea = 0; eb = 0; eov = 1;
    end else begin
      ea = a / b; eb = a % b; eov = 0;
    end
  endtask

  task automatic check_res(input string req, input int ea, input int eb, input bit eov);
    checks++;
    if (a_out !== ea[W-1:0] || b_out !== eb[W-1:0] || ov_out !== eov || c_out !== 1'b0) begin
      errors++;
      $display("FAIL %s actual a=%0d b=%0d c=%0d ov=%0d expected a=%0d b=%0d c=0 ov=%0d",
               req, a_out, b_out, c_out, ov_out, ea, eb, eov);
    end
  endtask

  // hold_start: keep start high while busy (R7); scramble: change inputs while busy (R8)
  task automatic run_op(input bit op, input int a, input int b,
                        input bit hold_start, input bit scramble, input string req);
    int ea, eb; bit eov; bit bad;
    bad = 0;
    @(negedge clk);
    op_sel = op; a_in = a[W-1:0]; b_in = b[W-1:0]; start = 1'b1;
    @(negedge clk);
    if (!hold_start) start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (done || !busy) bad = 1;
      if (scramble) begin
        a_in = W'($urandom); b_in = W'($urandom); op_sel = ~op_sel;
      end
      if (i < 3) @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);
    checks++;
    if (bad || done !== 1'b1 || busy !== 1'b0) begin
      errors++;
      $display("FAIL R1 timing actual done=%0d busy=%0d early=%0d expected done=1 busy=0 early=0",
               done, busy, bad);
    end
    model(op, a, b, ea, eb, eov);
    check_res(req, ea, eb, eov);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int bset [12] = '{0, 1, 2, 3, 5, 15, 16, 127, 128, 200, 254, 255};
    int aset [4]  = '{0, 1, 170, 255};
    int ea, eb; bit eov;
    rst = 1'b1; start = 1'b0; op_sel = 1'b0; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (a_out !== 0 || b_out !== 0 || c_out !== 0 || ov_out !== 0 || done !== 0 || busy !== 0) begin
      errors++;
      $display("FAIL R9 reset actual a=%0d b=%0d c=%0d ov=%0d done=%0d busy=%0d expected all 0",
               a_out, b_out, c_out, ov_out, done, busy);
    end

    // R3 R4 multiply sweep, R5 R6 divide sweep (R2 carry checked in each)
    for (int a = 0; a < 256; a++)
      for (int j = 0; j < 12; j++) begin
        run_op(1'b0, a, bset[j], 1'b0, 1'b0, "R3 R4 R2 mul sweep");
        run_op(1'b1, a, bset[j], 1'b0, 1'b0, (bset[j] == 0) ? "R5 div by zero" : "R6 R2 div sweep");
      end
    for (int b = 0; b < 256; b++)
      for (int j = 0; j < 4; j++) begin
        run_op(1'b0, aset[j], b, 1'b0, 1'b0, "R4 mul b sweep");
        run_op(1'b1, aset[j], b, 1'b0, 1'b0, "R6 div b sweep");
      end

    // carry set by nothing: divide-by-zero still clears it (R2)
    run_op(1'b1, 77, 0, 1'b0, 1'b0, "R2 R5 carry after div zero");

    // R7: start held high while busy, with changing inputs
    run_op(1'b0, 200, 3, 1'b1, 1'b1, "R7 start ignored mul");
    run_op(1'b1, 250, 7, 1'b1, 1'b1, "R7 start ignored div");
    // R8: operands change while busy, start low
    run_op(1'b0, 255, 255, 1'b0, 1'b1, "R8 capture mul");
    run_op(1'b1, 99, 0, 1'b0, 1'b1, "R8 capture div zero");

    // R7: no extra operation after a held start
    @(negedge clk);
    checks++;
    if (busy !== 1'b0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R7 extra op actual busy=%0d done=%0d expected busy=0 done=0", busy, done);
    end

    // R9: idle cycles with moving inputs keep the last result
    run_op(1'b1, 200, 9, 1'b0, 1'b0, "R6 before hold");
    model(1'b1, 200, 9, ea, eb, eov);
    for (int k = 0; k < 5; k++) begin
      a_in = W'($urandom); b_in = W'($urandom); op_sel = ~op_sel;
      @(negedge clk);
      check_res("R9 hold while idle", ea, eb, eov);
      checks++;
      if (done !== 1'b0) begin
        errors++;
        $display("FAIL R9 done while idle actual=%0d expected=0", done);
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule